// File: doc/BRIEF.md
# Selectable Arithmetic Microoperation Unit

This block is a purely combinational arithmetic unit of parameterised width. It produces every operation it offers from a single ripple-carry adder. A two-bit operand selector steers what reaches the adder's second input: the operand B, its bitwise inverse, all zeros or all ones. A separate carry-in bit is fed into the adder's lowest stage. The result is D = A + Y + Cin, reduced modulo 2^W, and the bit that leaves the top stage is reported as the carry-out.

The eight combinations of selector and carry-in give plain addition, addition plus one, subtraction, subtraction minus one (borrow), passing A through, incrementing A and decrementing A. Passing A through appears twice. The datapath around the unit registers the result wherever it needs to. The unit itself holds no state.

Top module: `arith_microop_unit`

## Requirements
- R1: With sel = 2'b00 and cin = 0, d equals (a + b) mod 2^W and cout is 1 exactly when a + b >= 2^W.
- R2: With sel = 2'b00 and cin = 1, d equals (a + b + 1) mod 2^W and cout is 1 exactly when a + b + 1 >= 2^W.
- R3: With sel = 2'b01 and cin = 1, d equals (a - b) mod 2^W and cout is 1 exactly when a >= b (no borrow).
- R4: With sel = 2'b01 and cin = 0, d equals (a - b - 1) mod 2^W and cout is 1 exactly when a > b.
- R5: With sel = 2'b10 and cin = 0, d equals a and cout is 0.
- R6: With sel = 2'b10 and cin = 1, d equals (a + 1) mod 2^W. cout is 1 only when a is all ones, in which case d is 0.
- R7: With sel = 2'b11 and cin = 0, d equals (a - 1) mod 2^W. cout is 0 only when a is 0, in which case d is all ones.
- R8: With sel = 2'b11 and cin = 1, d equals a and cout is 1.
- R9: The outputs follow any input change within the same clock period, with no clock edge involved, and the unit holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand, always applied unmodified to the adder |
| b | input | W | Second operand source before steering |
| sel | input | 2 | Operand steering: 00 b, 01 inverse of b, 10 zeros, 11 ones |
| cin | input | 1 | Carry into the lowest adder stage |
| d | output | W | Adder result modulo 2^W |
| cout | output | 1 | Carry out of the top adder stage |

## Verification
The two effects that coincide on one evaluation are the wrapped result and the carry-out. Examples are incrementing all ones, which gives zero and a carry, and decrementing zero, which gives all ones and no carry. Every subtraction also decides borrow and difference together. The bench sweeps every operand pair under all eight selector and carry-in codes. It judges d and cout jointly against an integer model, so a wrap that loses its carry, or a carry without a wrap, is reported. A separate mid-period input change confirms that the outputs settle without a clock edge.

// File: rtl/aru_pkg.sv
package aru_pkg;
  // Steering codes for the adder's second operand.
  typedef enum logic [1:0] {
    YSEL_PLAIN  = 2'b00,
    YSEL_INVERT = 2'b01,
    YSEL_ZEROS  = 2'b10,
    YSEL_ONES   = 2'b11
  } ysel_e;
endpackage

// File: rtl/aru_operand_steer.sv
module aru_operand_steer
  import aru_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] y_out
);
  ysel_e code;

  always_comb begin
    code = ysel_e'(sel);
    unique case (code)
      YSEL_PLAIN:  y_out = b_in;
      YSEL_INVERT: y_out = ~b_in;
      YSEL_ZEROS:  y_out = '0;
      YSEL_ONES:   y_out = '1;
      default:     y_out = b_in;
    endcase
  end
endmodule

// File: rtl/aru_fa_cell.sv
module aru_fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;

  always_comb begin
    p  = x ^ y;
    s  = p ^ ci;
    co = (x & y) | (p & ci);
  end
endmodule

// File: rtl/aru_ripple_adder.sv
module aru_ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int TOP = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic c_here;
    logic c_next;
    if (i == 0) begin : g_first
      assign c_here = ci;
    end else begin : g_rest
      assign c_here = g_stage[i-1].c_next;
    end
    aru_fa_cell u_cell (
      .x  (x[i]),
      .y  (y[i]),
      .ci (c_here),
      .s  (s[i]),
      .co (c_next)
    );
  end

  assign co = g_stage[TOP].c_next;
endmodule

// File: rtl/arith_microop_unit.sv
module arith_microop_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  input  logic         cin,
  output logic [W-1:0] d,
  output logic         cout
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZERO = {W{1'b0}};

  logic [W-1:0] y_steered;

  aru_operand_steer #(.W(W)) u_steer (
    .sel   (sel),
    .b_in  (b),
    .y_out (y_steered)
  );

  aru_ripple_adder #(.W(W)) u_adder (
    .x  (a),
    .y  (y_steered),
    .ci (cin),
    .s  (d),
    .co (cout)
  );

  always_comb begin
    // R5
    xfer_zero_chk: assert (!(sel == 2'b10 && !cin) || (d == a && !cout));
    // R8
    xfer_ones_chk: assert (!(sel == 2'b11 && cin) || (d == a && cout));
    // R6
    inc_wrap_chk: assert (!(sel == 2'b10 && cin) || (cout == (a == ALL_ONES)));
    // R7
    dec_wrap_chk: assert (!(sel == 2'b11 && !cin) || (cout == (a != ALL_ZERO)));
    // R3
    no_borrow_chk: assert (!(sel == 2'b01 && cin) || (cout == (a >= b)));
    // R4
    borrow_sub_chk: assert (!(sel == 2'b01 && !cin) || (cout == (a > b)));
  end
endmodule

// File: tb/arith_microop_unit_test.sv
`timescale 1ns/1ps
module arith_microop_unit_test;
  localparam int W = 4;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a, b, d;
  logic [1:0] sel;
  logic cin, cout;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  arith_microop_unit #(.W(W)) uut (
    .a(a), .b(b), .sel(sel), .cin(cin), .d(d), .cout(cout)
  );

  function automatic string tag_of(input int s, input int c);
    case ({s[1:0], c[0]})
      3'b000: return "R1";
      3'b001: return "R2";
      3'b011: return "R3";
      3'b010: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Behavioural reference: expected {cout, d} as an integer.
  function automatic int model(input int av, input int bv, input int s, input int c);
    int r;
    int k;
    case ({s[1:0], c[0]})
      3'b000: begin r = (av + bv) % MOD;         k = (av + bv >= MOD); end
      3'b001: begin r = (av + bv + 1) % MOD;     k = (av + bv + 1 >= MOD); end
      3'b011: begin r = (av - bv + MOD) % MOD;   k = (av >= bv); end
      3'b010: begin r = (av - bv - 1 + 2*MOD) % MOD; k = (av > bv); end
      3'b100: begin r = av;                      k = 0; end
      3'b101: begin r = (av + 1) % MOD;          k = (av == MOD - 1); end
      3'b110: begin r = (av - 1 + MOD) % MOD;    k = (av != 0); end
      default: begin r = av;                     k = 1; end
    endcase
    return k * MOD + r;
  endfunction

  task automatic compare(input string tag, input int exp);
    int got;
    got = int'(cout) * MOD + int'(d);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d sel=%0d cin=%0d actual cout/d=%0d/%0d expected %0d/%0d",
               tag, a, b, sel, cin, got / MOD, got % MOD, exp / MOD, exp % MOD);
    end
  endtask

  task automatic apply_and_check(input int av, input int bv, input int s, input int c);
    @(negedge clk);
    a = W'(av); b = W'(bv); sel = 2'(s); cin = c[0];
    @(posedge clk);
    #1;
    compare(tag_of(s, c), model(av, bv, s, c));
  endtask

  initial begin
    a = '0; b = '0; sel = 2'b00; cin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1", 0); // reset-time state: 0 + 0
    rst_n = 1'b1;

    // Named corners
    apply_and_check(MOD-1, 0, 2'b10, 1);   // R6 increment wraps with carry
    apply_and_check(0, 0, 2'b11, 0);       // R7 decrement of zero, no carry
    apply_and_check(5, 5, 2'b01, 1);       // R3 equal operands, no borrow
    apply_and_check(5, 5, 2'b01, 0);       // R4 equal operands, borrow
    apply_and_check(MOD-1, 1, 2'b00, 0);   // R1 overflow
    apply_and_check(MOD-1, MOD-1, 2'b00, 1); // R2 max sum
    apply_and_check(9, 3, 2'b10, 0);       // R5
    apply_and_check(9, 3, 2'b11, 1);       // R8

    // Exhaustive sweep of every code and operand pair
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int av = 0; av < MOD; av++)
          for (int bv = 0; bv < MOD; bv++)
            apply_and_check(av, bv, s, c);

    // R9: change inputs mid-period, no edge in between
    @(posedge clk);
    #1;
    a = 4'd3; b = 4'd7; sel = 2'b00; cin = 1'b0;
    #0.5;
    compare("R9", model(3, 7, 0, 0));
    a = 4'd2; sel = 2'b01; cin = 1'b1;
    #0.5;
    compare("R9", model(2, 7, 1, 1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule